// File: doc/BRIEF.md
# Structure-Agnostic IQ Byte Payload Packer

This block gathers a continuous byte stream of radio IQ samples and slices it into fixed-size Ethernet payloads. Slicing is by byte count alone. The block never inspects the sample content or frame layout. Each output payload is a beat stream with a final-beat marker. On that final beat the block also reports how many basic frames began inside the payload.

The line-rate code gives the number of IQ bytes in one basic frame. That number is 15 times the code's rate multiple. The block uses it to track basic-frame starts by itself. An optional frame strobe on the input realigns that tracking whenever it is seen.

A basic frame that crosses a payload boundary is split. Its remaining bytes open the next payload, and the frame is counted only in the payload where it began. Lower line rates fill a payload more slowly, so packing latency rises as the line rate falls. The output side tolerates downstream stalls through a small buffer. A byte that arrives while that buffer is full and stalled is dropped and flagged.

Top module: `cpri_payload_packer`

## Requirements
- R1: After reset, `out_valid_o` and `overflow_o` are low.
- R2: Each payload holds exactly the number of bytes selected by `cfg_size_i`: code 0 gives 256, code 1 gives 512, code 2 gives 1024, and code 3 is treated as 256.
- R3: Payload bytes leave in arrival order with their values unchanged, whatever their content.
- R4: `out_last_o` is high on the final byte of each payload and low on every other byte.
- R5: Bytes per basic frame equal 15 times the rate multiple. The multiple is selected by `cfg_rate_i`: codes 0..6 map to 1, 2, 4, 5, 8, 10, 16, and code 7 maps to 16. When no strobe is present, a new frame starts every that many bytes. On the final beat, `out_frames_o` equals the number of frame starts inside the payload; on other beats it is 0.
- R6: A byte accepted with `in_bf_start_i` high always counts as a frame start, and frame tracking restarts from that byte.
- R7: A frame that crosses a payload boundary continues into the next payload with no byte lost, and it is counted only in the payload where it began.
- R8: The size and rate codes are taken when the first byte of a payload is accepted. A change made while a payload is partly filled takes effect from the next payload.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the output beat (data, last and frame count) is held unchanged on the following cycle.
- R10: An input byte that arrives while the buffer is full and `out_ready_i` is low is dropped. In that case `overflow_o` pulses high for one cycle on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input IQ byte |
| in_bf_start_i | input | 1 | Marks the byte as the first byte of a basic frame |
| cfg_size_i | input | 2 | Payload size code |
| cfg_rate_i | input | 3 | Line-rate code |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 8 | Output payload byte |
| out_last_o | output | 1 | Final byte of a payload |
| out_frames_o | output | 11 | Frame starts in the payload, valid on the final byte |
| overflow_o | output | 1 | One-cycle pulse when an input byte was dropped |

## Verification
The packer is fed continuous streams at several size and rate pairings. The frame counts that result can only come out right if the bytes-per-frame decode is right. A stream of two payloads at the smallest frame size places a frame across the boundary. That test separates per-payload counting from leaked or double counts. Strobes placed off the natural frame grid show whether realignment happens. A size change made partway through a payload shows whether configuration is taken at the boundary or immediately. A long stall first checks the hold behaviour and then pushes bytes past the buffer depth, which proves that the overflow pulse fires and that exactly the dropped bytes are missing.

// File: rtl/cpp_pkg.sv
package cpp_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned PAY_MAX    = 1024;
  localparam int unsigned LEN_W      = $clog2(PAY_MAX) + 1;
  localparam int unsigned FCNT_W     = $clog2(PAY_MAX + 1);
  localparam int unsigned BPF_W      = 8;
  localparam int unsigned BASE_BYTES = 15;
  localparam int unsigned SIZE_W     = 2;
  localparam int unsigned RATE_W     = 3;

  function automatic logic [4:0] rate_mult(input logic [RATE_W-1:0] code);
    case (code)
      3'd0:    rate_mult = 5'd1;
      3'd1:    rate_mult = 5'd2;
      3'd2:    rate_mult = 5'd4;
      3'd3:    rate_mult = 5'd5;
      3'd4:    rate_mult = 5'd8;
      3'd5:    rate_mult = 5'd10;
      default: rate_mult = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/cpp_cfg_decode.sv
module cpp_cfg_decode
  import cpp_pkg::*;
(
  input  logic [SIZE_W-1:0] size_code_i,
  input  logic [RATE_W-1:0] rate_code_i,
  output logic [LEN_W-1:0]  pay_len_o,
  output logic [BPF_W-1:0]  bpf_o
);
  always_comb begin
    case (size_code_i)
      2'd1:    pay_len_o = LEN_W'(512);
      2'd2:    pay_len_o = LEN_W'(1024);
      default: pay_len_o = LEN_W'(256);
    endcase
    bpf_o = BPF_W'(BASE_BYTES * rate_mult(rate_code_i));
  end
endmodule

// File: rtl/cpp_pack_ctrl.sv
module cpp_pack_ctrl
  import cpp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              bf_strobe_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic [BPF_W-1:0]  cfg_bpf_i,
  output logic              last_o,
  output logic [FCNT_W-1:0] frames_o
);
  logic [LEN_W-1:0]  pay_cnt_q, len_q, len_eff;
  logic [BPF_W-1:0]  bpf_q, bpf_eff, pos_q, pos_base, pos_nxt;
  logic [FCNT_W-1:0] fcnt_q;
  logic              idle, start;

  // config bypassed at payload start, frozen otherwise
  assign idle    = (pay_cnt_q == '0);
  assign len_eff = idle ? cfg_len_i : len_q;
  assign bpf_eff = idle ? cfg_bpf_i : bpf_q;
  assign start   = bf_strobe_i || (pos_q == '0);
  assign last_o  = (pay_cnt_q == len_eff - LEN_W'(1));
  assign frames_o = fcnt_q + FCNT_W'(start);

  always_comb begin
    pos_base = start ? BPF_W'(1) : pos_q + BPF_W'(1);
    pos_nxt  = (pos_base >= bpf_eff) ? '0 : pos_base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pay_cnt_q <= '0;
      len_q     <= LEN_W'(256);
      bpf_q     <= BPF_W'(BASE_BYTES);
      pos_q     <= '0;
      fcnt_q    <= '0;
    end else if (acc_i) begin
      if (idle) begin
        len_q <= cfg_len_i;
        bpf_q <= cfg_bpf_i;
      end
      pay_cnt_q <= last_o ? '0 : pay_cnt_q + LEN_W'(1);
      fcnt_q    <= last_o ? '0 : frames_o;
      pos_q     <= pos_nxt;
    end
  end

  AST_PAY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_cnt_q != '0) |-> (pay_cnt_q < len_q)); // R2
  AST_FCNT_LE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcnt_q <= FCNT_W'(pay_cnt_q)); // R5
endmodule

// File: rtl/cpp_byte_fifo.sv
module cpp_byte_fifo #(
  parameter int unsigned DW    = 20,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [AW:0]   cnt_q;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == (AW+1)'(DEPTH));
  assign rd_data_o = mem[rd_ptr_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= bump(wr_ptr_q);
      if (rd_i) rd_ptr_q <= bump(rd_ptr_q);
      case ({wr_i, rd_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (!full_o || rd_i)); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !empty_o); // R9
endmodule

// File: rtl/cpri_payload_packer.sv
module cpri_payload_packer
  import cpp_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_bf_start_i,
  input  logic [SIZE_W-1:0] cfg_size_i,
  input  logic [RATE_W-1:0] cfg_rate_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o,
  output logic [FCNT_W-1:0] out_frames_o,
  output logic              overflow_o
);
  localparam int unsigned ENT_W = DATA_W + 1 + FCNT_W;

  logic [LEN_W-1:0]  dec_len;
  logic [BPF_W-1:0]  dec_bpf;
  logic              acc, last, full, empty, pop, ovf_q;
  logic [FCNT_W-1:0] frames, frames_w;
  logic [ENT_W-1:0]  wr_ent, rd_ent;

  cpp_cfg_decode u_dec (
    .size_code_i (cfg_size_i),
    .rate_code_i (cfg_rate_i),
    .pay_len_o   (dec_len),
    .bpf_o       (dec_bpf)
  );

  // a full buffer still accepts when a beat leaves in the same cycle
  assign acc = in_valid_i && (!full || out_ready_i);
  assign pop = !empty && out_ready_i;

  cpp_pack_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .bf_strobe_i (in_bf_start_i),
    .cfg_len_i   (dec_len),
    .cfg_bpf_i   (dec_bpf),
    .last_o      (last),
    .frames_o    (frames)
  );

  assign frames_w = last ? frames : '0;
  assign wr_ent   = {in_data_i, last, frames_w};

  cpp_byte_fifo #(.DW(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (acc),
    .wr_data_i (wr_ent),
    .rd_i      (pop),
    .rd_data_o (rd_ent),
    .empty_o   (empty),
    .full_o    (full)
  );

  assign out_valid_o  = !empty;
  assign out_data_o   = rd_ent[ENT_W-1 -: DATA_W];
  assign out_last_o   = rd_ent[FCNT_W];
  assign out_frames_o = rd_ent[FCNT_W-1:0];
  assign overflow_o   = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= in_valid_i && full && !out_ready_i;
  end

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)
      && $stable(out_last_o) && $stable(out_frames_o))); // R9
  AST_OVF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> $past(in_valid_i && !out_ready_i)); // R10
  AST_LAST_ONLY_FRAMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |-> (out_frames_o == '0)); // R5
endmodule

// File: tb/cpri_payload_packer_tb_top.sv
module cpri_payload_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_bf = 1'b0;
  logic [1:0]  cfg_size = '0;
  logic [2:0]  cfg_rate = '0;
  logic        out_ready = 1'b1;
  logic        out_valid, out_last, overflow;
  logic [7:0]  out_data;
  logic [10:0] out_frames;

  always #10 clk = ~clk;

  cpri_payload_packer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_bf_start_i(in_bf), .cfg_size_i(cfg_size), .cfg_rate_i(cfg_rate),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_last_o(out_last), .out_frames_o(out_frames), .overflow_o(overflow)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0]  exp_d  [0:4095];
  logic        exp_l  [0:4095];
  logic [10:0] exp_f  [0:4095];
  int wr_idx = 0, rd_idx = 0, mism = 0;
  int plen [0:15];
  int pfr  [0:15];
  int np = 0, cur_len = 0, ovf_cnt = 0;

  // reference model state, from R2, R5, R6, R8
  int m_cnt = 0, m_len = 256, m_bpf = 15, m_pos = 0, m_fc = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int mult_of(input logic [2:0] c);
    case (c)
      3'd0: return 1;  3'd1: return 2;  3'd2: return 4;  3'd3: return 5;
      3'd4: return 8;  3'd5: return 10; default: return 16;
    endcase
  endfunction

  function automatic int len_of(input logic [1:0] c);
    case (c)
      2'd1: return 512;
      2'd2: return 1024;
      default: return 256;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && overflow) ovf_cnt++;
    if (rst_n && out_valid && out_ready) begin
      if (out_data !== exp_d[rd_idx] || out_last !== exp_l[rd_idx] ||
          out_frames !== exp_f[rd_idx]) mism++;
      rd_idx++;
      cur_len++;
      if (out_last) begin
        plen[np] = cur_len;
        pfr[np] = int'(out_frames);
        np++;
        cur_len = 0;
      end
    end
  end

  task automatic push(input logic [7:0] d, input bit s, input bit modeled);
    int st;
    bit lst;
    @(posedge clk); #2;
    in_valid = 1'b1; in_data = d; in_bf = s;
    if (modeled) begin
      if (m_cnt == 0) begin
        m_len = len_of(cfg_size);
        m_bpf = 15 * mult_of(cfg_rate);
      end
      st  = (s || m_pos == 0) ? 1 : 0;
      lst = (m_cnt == m_len - 1);
      exp_d[wr_idx] = d;
      exp_l[wr_idx] = lst;
      exp_f[wr_idx] = lst ? 11'(m_fc + st) : 11'd0;
      wr_idx++;
      m_pos = st ? 1 : m_pos + 1;
      if (m_pos >= m_bpf) m_pos = 0;
      m_fc  = lst ? 0 : m_fc + st;
      m_cnt = lst ? 0 : m_cnt + 1;
    end
  endtask

  task automatic idle_and_drain();
    @(posedge clk); #2;
    in_valid = 1'b0; in_bf = 1'b0;
    repeat (30) @(posedge clk);
  endtask

  task automatic start_test();
    wr_idx = 0; rd_idx = 0; mism = 0; np = 0; cur_len = 0;
  endtask

  task automatic end_test(input string req, input int n_beats);
    check(mism == 0, {req, " R3 beat content"}, mism, 0);
    check(rd_idx == n_beats, {req, " beat count"}, rd_idx, n_beats);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(overflow == 1'b0, "R1 overflow after reset", int'(overflow), 0);
  endtask

  task automatic t_basic();
    start_test();
    cfg_size = 2'd0; cfg_rate = 3'd0;
    for (int i = 0; i < 512; i++) push(8'((i * 7 + 3) & 255), i == 0, 1'b1);
    idle_and_drain();
    end_test("R3 R4 basic", 512);
    check(np == 2, "R4 payload count", np, 2);
    check(plen[0] == 256, "R2 size0 len p0", plen[0], 256);
    check(plen[1] == 256, "R2 size0 len p1", plen[1], 256);
    check(pfr[0] == 18, "R5 frames rate0 p0", pfr[0], 18);
    check(pfr[1] == 17, "R7 split frame not recounted", pfr[1], 17);
  endtask

  task automatic t_size_rate();
    start_test();
    cfg_size = 2'd1; cfg_rate = 3'd3;
    for (int i = 0; i < 512; i++) push(8'(255 - (i & 255)), i == 0, 1'b1);
    cfg_size = 2'd2; cfg_rate = 3'd6;
    for (int i = 0; i < 1024; i++) push(8'((i * 13) & 255), i == 0, 1'b1);
    cfg_size = 2'd3; cfg_rate = 3'd0;
    for (int i = 0; i < 256; i++) push(8'(i & 255), i == 0, 1'b1);
    idle_and_drain();
    end_test("R2 R5 size/rate", 1792);
    check(plen[0] == 512, "R2 size1 len", plen[0], 512);
    check(pfr[0] == 7, "R5 frames rate3 (75 B)", pfr[0], 7);
    check(plen[1] == 1024, "R2 size2 len", plen[1], 1024);
    check(pfr[1] == 5, "R5 frames rate6 (240 B)", pfr[1], 5);
    check(plen[2] == 256, "R2 size3 len", plen[2], 256);
  endtask

  task automatic t_strobe();
    start_test();
    cfg_size = 2'd0; cfg_rate = 3'd0;
    for (int i = 0; i < 256; i++) push(8'h5a ^ 8'(i), (i == 0 || i == 7 || i == 9), 1'b1);
    idle_and_drain();
    end_test("R6 strobe", 256);
    check(pfr[0] == 19, "R6 strobe realign frames", pfr[0], 19);
  endtask

  task automatic t_cfg_change();
    start_test();
    cfg_size = 2'd0; cfg_rate = 3'd0;
    for (int i = 0; i < 100; i++) push(8'(i), i == 0, 1'b1);
    cfg_size = 2'd1;
    for (int i = 100; i < 768; i++) push(8'(i), 1'b0, 1'b1);
    idle_and_drain();
    end_test("R8 cfg change", 768);
    check(plen[0] == 256, "R8 mid-payload change ignored", plen[0], 256);
    check(plen[1] == 512, "R8 change applied next payload", plen[1], 512);
  endtask

  task automatic t_backpressure();
    logic [7:0] held;
    start_test();
    ovf_cnt = 0;
    cfg_size = 2'd0; cfg_rate = 3'd0;
    @(posedge clk); #2; out_ready = 1'b0;
    for (int i = 0; i < 10; i++) push(8'(8'hc0 + i), i == 0, i < 8);
    @(posedge clk); #2; in_valid = 1'b0; in_bf = 1'b0;
    @(negedge clk); held = out_data;
    check(out_valid == 1'b1, "R9 valid during stall", int'(out_valid), 1);
    check(held == 8'hc0, "R9 head byte during stall", int'(held), 'hc0);
    repeat (3) @(negedge clk);
    check(out_data == held && out_valid, "R9 data held", int'(out_data), int'(held));
    check(ovf_cnt == 2, "R10 overflow pulses", ovf_cnt, 2);
    @(posedge clk); #2; out_ready = 1'b1;
    repeat (20) @(posedge clk);
    end_test("R10 dropped bytes absent", 8);
    check(np == 0, "R4 no last in partial payload", np, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_basic();
    t_size_rate();
    t_strobe();
    t_cfg_change();
    check(ovf_cnt == 0, "R10 no overflow without stall", ovf_cnt, 0);
    t_backpressure();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule